// File: doc/BRIEF.md
# Differential Word Programming Controller for Resistive Memory

This controller sits between a host write port and a bit-addressable resistive memory array. For every accepted write it first reads the addressed word, compares it with the incoming data under the byte enables, and builds two masks: the bits that must go from 0 to 1 and the bits that must go from 1 to 0. Bits that already hold the requested value receive no energy. No erase step ever comes before a write.

The word is programmed one sub-word at a time so that only one sub-word's cells draw program current at once. Inside a sub-word the controller runs a SET pass and then a RESET pass. Each pass repeats a pulse, verify-read and check sequence, and drops every bit from the mask as soon as it reads back correctly. A pass that still has failing bits after the configured pulse limit ends the request with a program-fail status and the index of the failing sub-word. When the read-only input is high the program supply is off, and writes are refused.

States: `ST_IDLE`, `ST_READ`, `ST_CAPTURE`, `ST_SELECT`, `ST_SET_PULSE`, `ST_SET_VERIFY`, `ST_SET_CHECK`, `ST_RST_PULSE`, `ST_RST_VERIFY`, `ST_RST_CHECK`, `ST_FINISH`. Transitions:
- IDLE→READ on a request with read-only low.
- IDLE→FINISH on a request with read-only high (refused).
- READ→CAPTURE→SELECT.
- SELECT→SET_PULSE when the lowest pending sub-word has SET bits, SELECT→RST_PULSE when it has only RESET bits, and SELECT→FINISH when nothing is pending.
- SET_PULSE→SET_VERIFY→SET_CHECK.
- SET_CHECK→SET_PULSE when bits are left and the limit is not reached.
- SET_CHECK→RST_PULSE when SET is done and RESET bits remain, and SET_CHECK→SELECT when neither is left.
- SET_CHECK→FINISH on the limit (fail).
- The RESET states follow the same pattern, and RST_CHECK returns to SELECT.
- A pulse state goes to FINISH (refused) if read-only rises during the write.
- FINISH→IDLE.

Top module: `nvm_diff_writer`

## Requirements
- R1: After reset, req_ready is 1 and busy, done, arr_set_en and arr_reset_en are 0.
- R2: A bit whose stored value already equals the requested value never receives a pulse, and last_changed equals the number of enabled bits that differ.
- R3: A 0→1 bit is programmed only by SET pulses and a 1→0 bit only by RESET pulses. arr_set_en and arr_reset_en are never high together.
- R4: Byte enable k covers data bits 8k to 8k+7. Bits in lanes whose enable is 0 are never pulsed and keep their stored value.
- R5: Pulses are confined to one sub-word at a time (sub-word s = bits s·SUB_W to s·SUB_W+SUB_W−1), taken in ascending order. Sub-words with nothing to change are skipped at no cycle cost: a write changing one bit that needs one pulse completes 8 cycles after acceptance, whatever its sub-word.
- R6: Within a sub-word, every SET pulse comes before any RESET pulse.
- R7: Each bit is pulsed until a verify read shows its new value and is then dropped, so last_pulses equals the sum of pulses each changed bit needed.
- R8: A pass that fails verify after MAX_PULSES pulses ends with done_status 2, fail_sub set to the failing sub-word index, and no more than MAX_PULSES pulses in that pass.
- R9: While ro_mode is 1, arr_supply_en is 0, no pulse is issued, and a write request completes one cycle after acceptance with done_status 1 and the array unchanged.
- R10: A write with no differing bits completes with done_status 0, zero pulses, and done high 4 cycles after acceptance.
- R11: req_ready is high only when idle. busy is high from acceptance through the one-cycle done pulse and low afterwards. Status 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ro_mode | input | 1 | Read-only mode, program supply off |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address |
| req_data | input | WORD_W | New word data |
| req_be | input | WORD_W/8 | Byte-lane enables |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 refused, 2 program fail |
| fail_sub | output | SUB_IDX_W | Sub-word that failed verify |
| last_pulses | output | PULSE_W | Bit-pulses issued by the last write |
| last_changed | output | CHG_W | Bits that differed in the last write |
| arr_supply_en | output | 1 | Program supply enable |
| arr_addr | output | ADDR_W | Array word address |
| arr_rd_en | output | 1 | Array read strobe, data one cycle later |
| arr_rd_data | input | WORD_W | Array read data |
| arr_set_en | output | 1 | SET pulse strobe |
| arr_reset_en | output | 1 | RESET pulse strobe |
| arr_bit_mask | output | WORD_W | Bits that receive the current pulse |

## Verification
The in-RTL properties watch, on every cycle, that SET and RESET never overlap and that no pulse fires with the supply off. They also check that a SET mask only touches bits requested as 1 and a RESET mask only bits requested as 0, that masks stay inside enabled lanes, that the per-pass pulse count stays under the limit, and that busy falls only after a single done pulse. What only the bench scenarios can show comes from the behavioural cell model: that bits already correct never receive energy, the ascending sub-word order and SET-before-RESET ordering, the exact pulse totals for random per-bit pulse needs, the fail index, and the completion latencies for no-change, refused and sparse writes.

// File: rtl/nvm_diff_pkg.sv
package nvm_diff_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_READ,
        ST_CAPTURE,
        ST_SELECT,
        ST_SET_PULSE,
        ST_SET_VERIFY,
        ST_SET_CHECK,
        ST_RST_PULSE,
        ST_RST_VERIFY,
        ST_RST_CHECK,
        ST_FINISH
    } wr_state_e;

    typedef enum logic [1:0] {
        WR_OK        = 2'd0,
        WR_REFUSED   = 2'd1,
        WR_PROG_FAIL = 2'd2
    } wr_status_e;

endpackage

// File: rtl/nvm_popcount.sv
module nvm_popcount #(
    parameter int W     = 32,
    parameter int OUT_W = 6
) (
    input  logic [W-1:0]     vec,
    output logic [OUT_W-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + OUT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/nvm_diff_mask.sv
module nvm_diff_mask #(
    parameter int WORD_W = 32,
    parameter int BE_W   = 4
) (
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] new_word,
    input  logic [BE_W-1:0]   lane_en,
    output logic [WORD_W-1:0] lane_bits,
    output logic [WORD_W-1:0] set_mask,
    output logic [WORD_W-1:0] rst_mask,
    output logic [WORD_W-1:0] diff_mask
);
    for (genvar b = 0; b < WORD_W; b++) begin : g_lane
        assign lane_bits[b] = lane_en[b/8];
    end

    assign set_mask  = new_word & ~old_word & lane_bits;
    assign rst_mask  = ~new_word & old_word & lane_bits;
    assign diff_mask = set_mask | rst_mask;
endmodule

// File: rtl/nvm_sub_finder.sv
module nvm_sub_finder #(
    parameter int WORD_W = 32,
    parameter int SUB_W  = 8,
    parameter int NSUB   = 4,
    parameter int IDX_W  = 2
) (
    input  logic [WORD_W-1:0] pending,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int s = NSUB - 1; s >= 0; s--) begin
            if (|pending[s*SUB_W +: SUB_W]) begin
                found = 1'b1;
                idx   = IDX_W'(s);
            end
        end
    end
endmodule

// File: rtl/nvm_diff_writer.sv
module nvm_diff_writer
    import nvm_diff_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int WORD_W     = 32,
    parameter int SUB_W      = 8,
    parameter int MAX_PULSES = 8,
    localparam int BE_W      = WORD_W / 8,
    localparam int NSUB      = WORD_W / SUB_W,
    localparam int SUB_IDX_W = (NSUB > 1) ? $clog2(NSUB) : 1,
    localparam int PULSE_W   = $clog2(WORD_W * MAX_PULSES + 1),
    localparam int CHG_W     = $clog2(WORD_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ro_mode,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_data,
    input  logic [BE_W-1:0]      req_be,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           done_status,
    output logic [SUB_IDX_W-1:0] fail_sub,
    output logic [PULSE_W-1:0]   last_pulses,
    output logic [CHG_W-1:0]     last_changed,
    output logic                 arr_supply_en,
    output logic [ADDR_W-1:0]    arr_addr,
    output logic                 arr_rd_en,
    input  logic [WORD_W-1:0]    arr_rd_data,
    output logic                 arr_set_en,
    output logic                 arr_reset_en,
    output logic [WORD_W-1:0]    arr_bit_mask
);
    localparam int PCNT_W = $clog2(MAX_PULSES + 1);

    wr_state_e              state, nxt_state;
    wr_status_e             status_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [WORD_W-1:0]      data_q;
    logic [BE_W-1:0]        be_q;
    logic [WORD_W-1:0]      set_rem, rst_rem;
    logic [SUB_IDX_W-1:0]   sub_idx, fail_sub_q;
    logic [PCNT_W-1:0]      pulse_cnt;
    logic [PULSE_W-1:0]     pulses_q;
    logic [CHG_W-1:0]       changed_q;

    logic [WORD_W-1:0]      lane_bits, m_set, m_rst, m_diff;
    logic [WORD_W-1:0]      sel_mask, fnd_mask, set_after, rst_after;
    logic                   fnd, set_left, rst_left_cur, rst_left_after, at_limit;
    logic [SUB_IDX_W-1:0]   fnd_idx;
    logic [CHG_W-1:0]       pop_diff, pop_pulse;

    nvm_diff_mask #(.WORD_W(WORD_W), .BE_W(BE_W)) u_mask (
        .old_word (arr_rd_data),
        .new_word (data_q),
        .lane_en  (be_q),
        .lane_bits(lane_bits),
        .set_mask (m_set),
        .rst_mask (m_rst),
        .diff_mask(m_diff)
    );

    nvm_sub_finder #(.WORD_W(WORD_W), .SUB_W(SUB_W), .NSUB(NSUB), .IDX_W(SUB_IDX_W)) u_find (
        .pending(set_rem | rst_rem),
        .found  (fnd),
        .idx    (fnd_idx)
    );

    nvm_popcount #(.W(WORD_W), .OUT_W(CHG_W)) u_pop_diff (
        .vec(m_diff),
        .cnt(pop_diff)
    );

    nvm_popcount #(.W(WORD_W), .OUT_W(CHG_W)) u_pop_pulse (
        .vec(arr_bit_mask),
        .cnt(pop_pulse)
    );

    // Sub-word masks for the active and the next pending sub-word
    always_comb begin
        for (int b = 0; b < WORD_W; b++) begin
            sel_mask[b] = ((b / SUB_W) == int'(sub_idx));
            fnd_mask[b] = ((b / SUB_W) == int'(fnd_idx));
        end
    end

    // Verify results: a SET bit is done when it reads 1, a RESET bit when it reads 0
    assign set_after      = set_rem & ~(arr_rd_data & sel_mask);
    assign rst_after      = rst_rem & ~(~arr_rd_data & sel_mask);
    assign set_left       = |(set_after & sel_mask);
    assign rst_left_cur   = |(rst_rem & sel_mask);
    assign rst_left_after = |(rst_after & sel_mask);
    assign at_limit       = (pulse_cnt == PCNT_W'(MAX_PULSES));

    // Next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:       if (req_valid) nxt_state = ro_mode ? ST_FINISH : ST_READ;
            ST_READ:       nxt_state = ST_CAPTURE;
            ST_CAPTURE:    nxt_state = ST_SELECT;
            ST_SELECT: begin
                if (!fnd)                        nxt_state = ST_FINISH;
                else if (|(set_rem & fnd_mask))  nxt_state = ST_SET_PULSE;
                else                             nxt_state = ST_RST_PULSE;
            end
            ST_SET_PULSE:  nxt_state = ro_mode ? ST_FINISH : ST_SET_VERIFY;
            ST_SET_VERIFY: nxt_state = ST_SET_CHECK;
            ST_SET_CHECK: begin
                if (set_left)          nxt_state = at_limit ? ST_FINISH : ST_SET_PULSE;
                else if (rst_left_cur) nxt_state = ST_RST_PULSE;
                else                   nxt_state = ST_SELECT;
            end
            ST_RST_PULSE:  nxt_state = ro_mode ? ST_FINISH : ST_RST_VERIFY;
            ST_RST_VERIFY: nxt_state = ST_RST_CHECK;
            ST_RST_CHECK: begin
                if (rst_left_after) nxt_state = at_limit ? ST_FINISH : ST_RST_PULSE;
                else                nxt_state = ST_SELECT;
            end
            ST_FINISH:     nxt_state = ST_IDLE;
            default:       nxt_state = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q   <= WR_OK;
            addr_q     <= '0;
            data_q     <= '0;
            be_q       <= '0;
            set_rem    <= '0;
            rst_rem    <= '0;
            sub_idx    <= '0;
            fail_sub_q <= '0;
            pulse_cnt  <= '0;
            pulses_q   <= '0;
            changed_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    addr_q     <= req_addr;
                    data_q     <= req_data;
                    be_q       <= req_be;
                    pulses_q   <= '0;
                    changed_q  <= '0;
                    fail_sub_q <= '0;
                    set_rem    <= '0;
                    rst_rem    <= '0;
                    status_q   <= ro_mode ? WR_REFUSED : WR_OK;
                end
                ST_CAPTURE: begin
                    set_rem   <= m_set;
                    rst_rem   <= m_rst;
                    changed_q <= pop_diff;
                end
                ST_SELECT: begin
                    sub_idx   <= fnd_idx;
                    pulse_cnt <= '0;
                end
                ST_SET_PULSE, ST_RST_PULSE: begin
                    if (ro_mode) begin
                        status_q <= WR_REFUSED;
                    end else begin
                        pulse_cnt <= pulse_cnt + 1'b1;
                        pulses_q  <= pulses_q + PULSE_W'(pop_pulse);
                    end
                end
                ST_SET_CHECK: begin
                    set_rem <= set_after;
                    if (set_left && at_limit) begin
                        status_q   <= WR_PROG_FAIL;
                        fail_sub_q <= sub_idx;
                    end
                    if (!set_left) pulse_cnt <= '0;
                end
                ST_RST_CHECK: begin
                    rst_rem <= rst_after;
                    if (rst_left_after && at_limit) begin
                        status_q   <= WR_PROG_FAIL;
                        fail_sub_q <= sub_idx;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (state == ST_IDLE);
        busy          = (state != ST_IDLE);
        done          = (state == ST_FINISH);
        done_status   = status_q;
        fail_sub      = fail_sub_q;
        last_pulses   = pulses_q;
        last_changed  = changed_q;
        arr_supply_en = !ro_mode;
        arr_addr      = addr_q;
        arr_rd_en     = (state == ST_READ) || (state == ST_SET_VERIFY) || (state == ST_RST_VERIFY);
        arr_set_en    = (state == ST_SET_PULSE) && !ro_mode;
        arr_reset_en  = (state == ST_RST_PULSE) && !ro_mode;
        arr_bit_mask  = '0;
        if (state == ST_SET_PULSE) arr_bit_mask = set_rem & sel_mask;
        if (state == ST_RST_PULSE) arr_bit_mask = rst_rem & sel_mask;
    end

    // Properties
    assert_set_reset_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_set_en && arr_reset_en));

    assert_set_only_to_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_set_en |-> ((arr_bit_mask & ~data_q) == '0));

    assert_reset_only_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_reset_en |-> ((arr_bit_mask & data_q) == '0));

    assert_mask_in_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_set_en || arr_reset_en) |-> ((arr_bit_mask & ~lane_bits) == '0));

    assert_no_pulse_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_set_en || arr_reset_en) |-> arr_supply_en);

    assert_pulse_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= PCNT_W'(MAX_PULSES));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ends_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

endmodule

// File: tb/nvm_diff_writer_tb.sv
module nvm_diff_writer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int WORD_W     = 32;
    localparam int SUB_W      = 8;
    localparam int MAX_PULSES = 8;
    localparam int BE_W       = WORD_W / 8;
    localparam int DEPTH      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ro_mode = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_data = '0;
    logic [BE_W-1:0]   req_be = '0;
    logic              busy, done;
    logic [1:0]        done_status;
    logic [1:0]        fail_sub;
    logic [8:0]        last_pulses;
    logic [5:0]        last_changed;
    logic              arr_supply_en, arr_rd_en, arr_set_en, arr_reset_en;
    logic [ADDR_W-1:0] arr_addr;
    logic [WORD_W-1:0] arr_rd_data = '0;
    logic [WORD_W-1:0] arr_bit_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_diff_writer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SUB_W(SUB_W), .MAX_PULSES(MAX_PULSES)) dut_i (
        .clk(clk), .rst_n(rst_n), .ro_mode(ro_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_be(req_be), .busy(busy), .done(done),
        .done_status(done_status), .fail_sub(fail_sub), .last_pulses(last_pulses),
        .last_changed(last_changed), .arr_supply_en(arr_supply_en), .arr_addr(arr_addr),
        .arr_rd_en(arr_rd_en), .arr_rd_data(arr_rd_data), .arr_set_en(arr_set_en),
        .arr_reset_en(arr_reset_en), .arr_bit_mask(arr_bit_mask)
    );

    // Behavioural cell array: each bit flips after need[] pulses
    logic [WORD_W-1:0] mem [DEPTH];
    int need [WORD_W];
    int got  [WORD_W];
    int cur_sub, cur_phase;
    int energy_viol = 0, dual_viol = 0, ro_viol = 0, sub_viol = 0, order_viol = 0;

    always @(posedge clk) begin
        if (arr_rd_en) arr_rd_data <= mem[arr_addr];
        if (arr_set_en && arr_reset_en) dual_viol++;
        if (arr_set_en || arr_reset_en) begin
            int lo;
            int s;
            logic [WORD_W-1:0] win;
            if (!arr_supply_en) ro_viol++;
            lo = -1;
            for (int i = WORD_W - 1; i >= 0; i--) if (arr_bit_mask[i]) lo = i;
            if (lo >= 0) begin
                s = lo / SUB_W;
                win = '0;
                for (int i = 0; i < WORD_W; i++) win[i] = ((i / SUB_W) == s);
                if ((arr_bit_mask & ~win) != '0) sub_viol++;
                if (s < cur_sub) sub_viol++;
                if (s == cur_sub && arr_set_en && cur_phase == 1) order_viol++;
                if (s != cur_sub) cur_phase = 0;
                cur_sub = s;
                if (arr_reset_en) cur_phase = 1;
            end
            for (int i = 0; i < WORD_W; i++) begin
                if (arr_bit_mask[i]) begin
                    if (arr_set_en && mem[arr_addr][i])    energy_viol++;
                    if (arr_reset_en && !mem[arr_addr][i]) energy_viol++;
                    got[i]++;
                    if (got[i] >= need[i]) mem[arr_addr][i] = arr_set_en;
                end
            end
        end
    end

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] lane_expand(input logic [BE_W-1:0] be);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) m[i] = be[i/8];
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old,
            input logic [WORD_W-1:0] nw, input logic [BE_W-1:0] be);
        logic [WORD_W-1:0] m;
        m = lane_expand(be);
        return (old & ~m) | (nw & m);
    endfunction

    function automatic int pulse_total(input logic [WORD_W-1:0] diff);
        int t = 0;
        for (int i = 0; i < WORD_W; i++) if (diff[i]) t += need[i];
        return t;
    endfunction

    int         obs_cyc;
    logic [1:0] obs_status;
    logic [1:0] obs_fail;
    int         obs_pulses, obs_changed;
    logic       obs_busy, idle_ready, idle_busy;

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d,
                            input logic [BE_W-1:0] be);
        for (int i = 0; i < WORD_W; i++) got[i] = 0;
        cur_sub = -1;
        cur_phase = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        req_data = d;
        req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        obs_cyc = 1;
        while (!done && obs_cyc < 5000) begin
            @(negedge clk);
            obs_cyc++;
        end
        obs_status  = done_status;
        obs_fail    = fail_sub;
        obs_pulses  = int'(last_pulses);
        obs_changed = int'(last_changed);
        obs_busy    = busy;
        @(negedge clk);
        idle_ready = req_ready;
        idle_busy  = busy;
        check(obs_busy == 1'b1 && idle_busy == 1'b0 && idle_ready == 1'b1, "R11",
              "busy through done then idle", {obs_busy, idle_busy, idle_ready}, 3'b101);
    endtask

    task automatic std_write(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d,
                             input logic [BE_W-1:0] be, input string req);
        logic [WORD_W-1:0] old, exp_w, diff;
        old   = mem[a];
        exp_w = merge_word(old, d, be);
        diff  = old ^ exp_w;
        do_write(a, d, be);
        check(obs_status == 2'd0, "R11", {req, " status ok"}, obs_status, 0);
        check(mem[a] == exp_w, req, "stored word", mem[a], exp_w);
        check(obs_changed == $countones(diff), "R2", "changed count", obs_changed, $countones(diff));
        check(obs_pulses == pulse_total(diff), "R7", "pulse total", obs_pulses, pulse_total(diff));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] d, old;
        void'($urandom(32'h5EED_0017));
        for (int a = 0; a < DEPTH; a++) mem[a] = $urandom;
        for (int i = 0; i < WORD_W; i++) begin need[i] = 1; got[i] = 0; end
        cur_sub = -1;
        cur_phase = 0;

        repeat (3) @(negedge clk);
        check(req_ready && !busy && !done && !arr_set_en && !arr_reset_en, "R1",
              "reset outputs", {req_ready, busy, done, arr_set_en, arr_reset_en}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !busy, "R1", "idle after reset", {req_ready, busy}, 2'b10);

        // R10: no differing bits
        do_write(4'd2, mem[2], 4'hF);
        check(obs_status == 2'd0, "R10", "status", obs_status, 0);
        check(obs_pulses == 0, "R10", "pulses", obs_pulses, 0);
        check(obs_changed == 0, "R10", "changed", obs_changed, 0);
        check(obs_cyc == 4, "R10", "latency", obs_cyc, 4);

        // R4: single lane and no lanes
        std_write(4'd3, ~mem[3], 4'b0010, "R4");
        old = mem[4];
        do_write(4'd4, ~old, 4'b0000);
        check(mem[4] == old && obs_pulses == 0, "R4", "no lane enabled", mem[4], old);

        // R9: read-only refusal
        ro_mode = 1'b1;
        @(negedge clk);
        check(arr_supply_en == 1'b0, "R9", "supply off", arr_supply_en, 0);
        old = mem[6];
        do_write(4'd6, ~old, 4'hF);
        check(obs_status == 2'd1, "R9", "refused status", obs_status, 1);
        check(obs_cyc == 1, "R9", "refuse latency", obs_cyc, 1);
        check(mem[6] == old && obs_pulses == 0, "R9", "array untouched", mem[6], old);
        ro_mode = 1'b0;

        // R5: single bit in the last sub-word, one pulse
        for (int i = 0; i < WORD_W; i++) need[i] = 1;
        old = mem[7];
        do_write(4'd7, old ^ 32'h0100_0000, 4'hF);
        check(obs_cyc == 8, "R5", "skip latency", obs_cyc, 8);
        check(mem[7] == (old ^ 32'h0100_0000), "R5", "bit written", mem[7], old ^ 32'h0100_0000);

        // R6 and R7: mixed directions in one sub-word, multi-pulse bits
        for (int i = 0; i < WORD_W; i++) need[i] = 1 + (i % 3);
        mem[8] = 32'h0F0F_00F0;
        std_write(4'd8, 32'hF0F0_0F0F, 4'hF, "R6");

        // R8: stubborn bit in sub-word 1
        for (int i = 0; i < WORD_W; i++) need[i] = 1;
        need[13] = MAX_PULSES + 2;
        old = mem[5];
        do_write(4'd5, old ^ (32'h1 << 13), 4'hF);
        check(obs_status == 2'd2, "R8", "fail status", obs_status, 2);
        check(obs_fail == 2'd1, "R8", "fail sub-word", obs_fail, 1);
        check(obs_pulses == MAX_PULSES, "R8", "pulses capped", obs_pulses, MAX_PULSES);
        check(mem[5] == old, "R8", "bit not flipped", mem[5], old);

        // Random writes
        for (int n = 0; n < 60; n++) begin
            for (int i = 0; i < WORD_W; i++) need[i] = 1 + int'($urandom % 4);
            d = $urandom;
            std_write(ADDR_W'($urandom), d, BE_W'($urandom), "R2");
        end

        check(energy_viol == 0, "R2", "pulses on correct bits", energy_viol, 0);
        check(dual_viol == 0, "R3", "SET and RESET together", dual_viol, 0);
        check(sub_viol == 0, "R5", "sub-word confinement/order", sub_viol, 0);
        check(order_viol == 0, "R6", "SET after RESET", order_viol, 0);
        check(ro_viol == 0, "R9", "pulse with supply off", ro_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule